// File: doc/BRIEF.md
# NAND command sequencer

This block carries out one raw transaction on a NAND flash bus from two software words: a control word that picks which phases run, and a timing word that sets every strobe width in clock cycles. A transaction always opens with a command byte. Then come any subset of four address bytes chosen by a mask, an optional data phase that moves bytes between the flash and one half of a local byte-wide buffer, and an optional wait for the ready/busy line.

The strobes (command latch, address latch, write and read enables), the four chip enables, the 8-bit I/O bus with its output enable and the write-protect pin are all driven here. The buffer is reached through a simple address/write-enable/data port that reads combinationally. Software sees progress through a busy bit and an interrupt status bit in the control readback. A level interrupt output follows the status when enabled. Writing the control word with its top bit set aborts a transaction in progress.

Top module: `nfc_sequencer`

## Requirements
- R1: After reset the block is idle: busy_o and irq_o low, CLE and ALE low, WE# and RE# high, every CE# high, control readback zero, write-protect pin high.
- R2: A control write with bit 31 = 0 while idle starts a transaction. Bit 31 of the readback and busy_o stay high until it ends. The readback shows the latched fields: bit 29 write enable, bit 28 read enable, [27:24] address mask, [23:16] command, bit 15 wait, bit 14 half, [13:12] chip, [9:0] length.
- R3: The command byte is driven with CLE high. WE# is low for max(T[7:0],1) cycles, then high for T[30:28]+1 end-of-cycle cycles, where T is the timing word. With no other phase this gives a busy time of exactly those two counts.
- R4: Address byte i (i = 0..3, ascending) is sent only when mask bit i is set. It carries bits [8i+7:8i] of the 30-bit address register, zero-extended, with ALE high, and uses the same strobe timing as the command.
- R5: With bit 29 set, length bytes are read from buffer addresses {half, offset} for offsets 0 upward and driven with WE# low for max(T[15:8],1) cycles. If bits 29 and 28 are both set, only the write phase runs and no RE# pulse occurs.
- R6: With bit 28 set and bit 29 clear, each of length bytes drives RE# low for R = max(T[23:16],1) cycles. The I/O value present in RE#-low cycle min(T[26:24]+1, R) is stored at {half, offset}. The buffer bytes beyond the length are not written.
- R7: While busy, exactly the CE# selected by bits [13:12] is low; all CE# are high when idle. The write-protect pin is low exactly when timing bit 31 is set.
- R8: With bit 15 set, completion waits after the last byte until rb_i (high = ready, synchronised through two flops) is high; the block stays busy while it is low.
- R9: Completion sets status bit 30 of the readback. irq_o is the status ANDed with the enable taken from bit 30 of the last control write. A control read or a new start clears the status.
- R10: A control write with bit 31 = 1 during a transaction returns the block to idle at that clock edge. All strobes and CE# are deasserted and the status is not set.
- R11: A data phase of length zero, or a transaction with no phase after the command, completes normally and sets the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_rd_i | input | 1 | Control word read strobe (clears status) |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word readback |
| cfg_wr_i | input | 1 | Timing word write strobe |
| cfg_wdata_i | input | 32 | Timing word write data |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | ADDR_W | Address register write data |
| busy_o | output | 1 | Transaction in progress |
| irq_o | output | 1 | Interrupt, status AND enable |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_ce_no | output | NUM_CE | Chip enables, active low |
| nand_wp_no | output | 1 | Write protect, active low |
| nand_io_o | output | 8 | I/O bus output data |
| nand_io_oe_o | output | 1 | I/O bus output enable |
| nand_io_i | input | 8 | I/O bus input data |
| nand_rb_i | input | 1 | Ready/busy line, high = ready |
| buf_addr_o | output | BUF_AW | Buffer byte address |
| buf_we_o | output | 1 | Buffer write enable |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, combinational |

## Verification
The bench builds the block with its defaults: four chip enables, a 1024-byte buffer split into two 512-byte halves, a 30-bit address register and a two-flop ready synchroniser. The timing word gives different widths to the latch, write and read strobes (2, 3 and 4 cycles), so a width taken from the wrong field shows up in the measured pulses. Read sampling is run with the sample point both inside the RE# window and past its end, which exercises the clamp. Both buffer halves, every chip-select decode the tests touch, and the top address byte with its zero-extended bits are reached with short transactions.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_WAIT
  } nfc_state_e;

  typedef struct packed {
    logic       wr_en;
    logic       rd_en;
    logic [3:0] addr_sel;
    logic [7:0] cmd;
    logic       wait_rdy;
    logic       half;
    logic [1:0] chip;
    logic [9:0] len;
  } nfc_job_t;

  typedef struct packed {
    logic       wp;
    logic [2:0] eoc;
    logic [2:0] sam;
    logic [7:0] re_t;
    logic [7:0] we_t;
    logic [7:0] ca_t;
  } nfc_timing_t;

  function automatic nfc_job_t unpack_job(input logic [31:0] w);
    nfc_job_t j;
    j.wr_en    = w[29];
    j.rd_en    = w[28];
    j.addr_sel = w[27:24];
    j.cmd      = w[23:16];
    j.wait_rdy = w[15];
    j.half     = w[14];
    j.chip     = w[13:12];
    j.len      = w[9:0];
    return j;
  endfunction

  function automatic nfc_timing_t unpack_timing(input logic [31:0] w);
    nfc_timing_t t;
    t.wp   = w[31];
    t.eoc  = w[30:28];
    t.sam  = w[26:24];
    t.re_t = w[23:16];
    t.we_t = w[15:8];
    t.ca_t = w[7:0];
    return t;
  endfunction

endpackage

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_rd_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_rdata_o,
  input  logic              cfg_wr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              addr_wr_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              stop_o,
  output nfc_job_t          job_o,
  output nfc_timing_t       timing_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              irq_o
);

  nfc_job_t          job_q;
  nfc_timing_t       tim_q;
  logic [ADDR_W-1:0] addr_q;
  logic              irq_en_q, irq_st_q;
  logic              unused_bits;

  assign unused_bits = ^ctrl_wdata_i[11:10] ^ cfg_wdata_i[27];

  assign start_o = ctrl_wr_i && !ctrl_wdata_i[31] && !busy_i;
  assign stop_o  = ctrl_wr_i &&  ctrl_wdata_i[31] &&  busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      job_q    <= '0;
      tim_q    <= '0;
      addr_q   <= '0;
      irq_en_q <= 1'b0;
      irq_st_q <= 1'b0;
    end else begin
      if (start_o)   job_q    <= unpack_job(ctrl_wdata_i);
      if (ctrl_wr_i) irq_en_q <= ctrl_wdata_i[30];
      if (cfg_wr_i)  tim_q    <= unpack_timing(cfg_wdata_i);
      if (addr_wr_i) addr_q   <= addr_wdata_i;
      // completion wins over a same-cycle read
      if (done_i)                      irq_st_q <= 1'b1;
      else if (ctrl_rd_i || start_o)   irq_st_q <= 1'b0;
    end
  end

  assign job_o    = job_q;
  assign timing_o = tim_q;
  assign addr_o   = addr_q;
  assign irq_o    = irq_st_q && irq_en_q;

  assign ctrl_rdata_o = {busy_i, irq_st_q, job_q.wr_en, job_q.rd_en, job_q.addr_sel,
                         job_q.cmd, job_q.wait_rdy, job_q.half, job_q.chip, 2'b00,
                         job_q.len};

  assert_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_st_q) |-> $past(done_i));

  assert_stop_no_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !irq_st_q) |=> !irq_st_q);

endmodule

// File: rtl/nfc_pins.sv
module nfc_pins #(
  parameter int NUM_CE      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CHIP_W     = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [CHIP_W-1:0] chip_i,
  input  logic              wp_i,
  input  logic              rb_i,
  output logic [NUM_CE-1:0] ce_no,
  output logic              wp_no,
  output logic              rb_rdy_o
);

  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    assign ce_no[g] = !(busy_i && (chip_i == CHIP_W'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rb_i};
  end

  assign rb_rdy_o = sync_q[SYNC_STAGES-1];
  assign wp_no    = !wp_i;

  assert_ce_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no) && (busy_i || (&ce_no)));

endmodule

// File: rtl/nfc_fsm.sv
module nfc_fsm
  import nfc_pkg::*;
#(
  parameter int BUF_AW  = 10,
  parameter int ADDR_W  = 30,
  parameter int LEN_W   = 10,
  localparam int NADDR  = 4,
  localparam int PAD_W  = 8 * NADDR - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NADDR-1:0]  addr_sel_i,
  input  logic [7:0]        cmd_i,
  input  logic              wait_rdy_i,
  input  logic              half_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        eoc_i,
  input  logic [2:0]        sam_i,
  input  logic [7:0]        re_t_i,
  input  logic [7:0]        we_t_i,
  input  logic [7:0]        ca_t_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rb_rdy_i,
  input  logic [7:0]        io_i,
  input  logic [7:0]        buf_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o
);

  nfc_state_e        state_q, state_d;
  logic              gap_q, gap_d;
  logic [7:0]        tmr_q, tmr_d;
  logic [1:0]        aidx_q, aidx_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;

  logic [7:0]        act_raw, act_len, samp_idx;
  logic              act_end, gap_end, is_latch;
  logic [NADDR:0]    low_mask;
  logic [NADDR-1:0]  rem_mask;
  logic [1:0]        first_idx;
  nfc_state_e        data_next, tail_next;
  logic [8*NADDR-1:0] pad_addr;
  logic [7:0]        addr_bytes [NADDR];

  assign pad_addr = {{PAD_W{1'b0}}, addr_i};
  for (genvar g = 0; g < NADDR; g++) begin : g_abyte
    assign addr_bytes[g] = pad_addr[8*g +: 8];
  end

  assign is_latch = (state_q == ST_CMD) || (state_q == ST_ADDR);

  // strobe width for the current byte, zero treated as one
  always_comb begin
    unique case (state_q)
      ST_WDATA: act_raw = we_t_i;
      ST_RDATA: act_raw = re_t_i;
      default:  act_raw = ca_t_i;
    endcase
  end
  assign act_len  = (act_raw == 8'd0) ? 8'd1 : act_raw;
  assign act_end  = (tmr_q == act_len - 8'd1);
  assign gap_end  = (tmr_q == {5'd0, eoc_i});
  assign samp_idx = ({5'd0, sam_i} < act_len) ? {5'd0, sam_i} : act_len - 8'd1;

  // address phases still pending after the current one
  assign low_mask = ({{NADDR{1'b0}}, 1'b1} << 1 << aidx_q) - 1'b1;
  assign rem_mask = (state_q == ST_ADDR) ? (addr_sel_i & ~low_mask[NADDR-1:0]) : addr_sel_i;

  always_comb begin
    first_idx = '0;
    for (int i = NADDR - 1; i >= 0; i--) begin
      if (rem_mask[i]) first_idx = 2'(i);
    end
  end

  assign tail_next = wait_rdy_i ? ST_WAIT : ST_IDLE;

  always_comb begin
    if (len_i == '0)   data_next = tail_next;
    else if (wr_en_i)  data_next = ST_WDATA;
    else if (rd_en_i)  data_next = ST_RDATA;
    else               data_next = tail_next;
  end

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    tmr_d   = tmr_q;
    aidx_d  = aidx_q;
    cnt_d   = cnt_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      gap_d   = 1'b0;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_d = ST_CMD;
            gap_d   = 1'b0;
            tmr_d   = '0;
            cnt_d   = '0;
            aidx_d  = '0;
          end
        end
        ST_WAIT: begin
          if (rb_rdy_i) state_d = ST_IDLE;
        end
        default: begin
          if (!gap_q) begin
            if (act_end) begin
              gap_d = 1'b1;
              tmr_d = '0;
            end else begin
              tmr_d = tmr_q + 8'd1;
            end
          end else if (!gap_end) begin
            tmr_d = tmr_q + 8'd1;
          end else begin
            gap_d = 1'b0;
            tmr_d = '0;
            if (is_latch) begin
              cnt_d = '0;
              if (|rem_mask) begin
                state_d = ST_ADDR;
                aidx_d  = first_idx;
              end else begin
                state_d = data_next;
              end
            end else if (cnt_q == len_i - 1'b1) begin
              state_d = tail_next;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= 1'b0;
      tmr_q   <= '0;
      aidx_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      tmr_q   <= tmr_d;
      aidx_q  <= aidx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = busy_o && !stop_i && (state_d == ST_IDLE);
  assign cle_o   = (state_q == ST_CMD);
  assign ale_o   = (state_q == ST_ADDR);
  assign we_no   = !((is_latch || (state_q == ST_WDATA)) && !gap_q);
  assign re_no   = !((state_q == ST_RDATA) && !gap_q);
  assign io_oe_o = is_latch || (state_q == ST_WDATA);

  always_comb begin
    unique case (state_q)
      ST_CMD:  io_o = cmd_i;
      ST_ADDR: io_o = addr_bytes[aidx_q];
      default: io_o = buf_rdata_i;
    endcase
  end

  assign buf_addr_o  = {half_i, cnt_q[BUF_AW-2:0]};
  assign buf_we_o    = (state_q == ST_RDATA) && !gap_q && (tmr_q == samp_idx);
  assign buf_wdata_o = io_i;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (we_no && re_no && !cle_o && !ale_o && !buf_we_o));

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o) && (we_no || re_no));

  assert_rd_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);

  assert_wait_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !rb_rdy_i && !stop_i) |=> busy_o);

  assert_stop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && we_no && re_no));

endmodule

// File: rtl/nfc_sequencer.sv
module nfc_sequencer
  import nfc_pkg::*;
#(
  parameter int NUM_CE      = 4,
  parameter int BUF_AW      = 10,
  parameter int ADDR_W      = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_rd_i,
  input  logic [31:0]       ctrl_wdata_i,
  output logic [31:0]       ctrl_rdata_o,
  input  logic              cfg_wr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              addr_wr_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [NUM_CE-1:0] nand_ce_no,
  output logic              nand_wp_no,
  output logic [7:0]        nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [7:0]        nand_io_i,
  input  logic              nand_rb_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);

  nfc_job_t          job;
  nfc_timing_t       tim;
  logic [ADDR_W-1:0] addr;
  logic              start, stop, busy, done, rb_rdy;

  nfc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_rd_i, .ctrl_wdata_i, .ctrl_rdata_o,
    .cfg_wr_i, .cfg_wdata_i, .addr_wr_i, .addr_wdata_i,
    .busy_i(busy), .done_i(done), .start_o(start), .stop_o(stop),
    .job_o(job), .timing_o(tim), .addr_o(addr), .irq_o
  );

  nfc_fsm #(.BUF_AW(BUF_AW), .ADDR_W(ADDR_W), .LEN_W(10)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop),
    .wr_en_i(job.wr_en), .rd_en_i(job.rd_en), .addr_sel_i(job.addr_sel),
    .cmd_i(job.cmd), .wait_rdy_i(job.wait_rdy), .half_i(job.half), .len_i(job.len),
    .eoc_i(tim.eoc), .sam_i(tim.sam), .re_t_i(tim.re_t), .we_t_i(tim.we_t),
    .ca_t_i(tim.ca_t), .addr_i(addr), .rb_rdy_i(rb_rdy), .io_i(nand_io_i),
    .buf_rdata_i, .busy_o(busy), .done_o(done), .cle_o(nand_cle_o),
    .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no), .io_o(nand_io_o),
    .io_oe_o(nand_io_oe_o), .buf_addr_o, .buf_we_o, .buf_wdata_o
  );

  nfc_pins #(.NUM_CE(NUM_CE), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk_i, .rst_ni, .busy_i(busy), .chip_i(job.chip), .wp_i(tim.wp),
    .rb_i(nand_rb_i), .ce_no(nand_ce_no), .wp_no(nand_wp_no), .rb_rdy_o(rb_rdy)
  );

  assign busy_o = busy;

endmodule

// File: tb/nfc_sequencer_tb.sv
module nfc_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG_A = 32'h1104_0302; // eoc=1 sam=1 re=4 we=3 ca=2
  localparam logic [31:0] CFG_B = 32'h1704_0302; // sam=7 (past RE window)

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_rd = 0, cfg_wr = 0, addr_wr = 0, rb = 1'b1;
  logic [31:0] ctrl_wdata = '0, cfg_wdata = '0, rdata;
  logic [29:0] addr_wdata = '0;
  logic busy, irq, cle, ale, we_n, re_n, wp_n, io_oe, buf_we;
  logic [3:0] ce_n;
  logic [7:0] io_o, io_i = '0, buf_wdata, buf_rdata;
  logic [9:0] buf_addr;
  logic [7:0] mem [1024];

  int n_chk = 0, n_fail = 0;
  int n_log = 0, we_low = 0, re_low = 0, rd_idx = 0;
  logic [7:0] log_byte [64];
  logic [1:0] log_kind [64];
  int         log_w    [64];
  logic [3:0] log_ce   [64];
  logic [7:0] l_io; logic [1:0] l_kind; logic [3:0] l_ce;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfc_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_rd_i(ctrl_rd),
    .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(rdata), .cfg_wr_i(cfg_wr),
    .cfg_wdata_i(cfg_wdata), .addr_wr_i(addr_wr), .addr_wdata_i(addr_wdata),
    .busy_o(busy), .irq_o(irq), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_ce_no(ce_n), .nand_wp_no(wp_n),
    .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_i), .nand_rb_i(rb),
    .buf_addr_o(buf_addr), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .buf_rdata_i(buf_rdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 13 + 5);
  endfunction

  assign buf_rdata = mem[buf_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (buf_we) begin
      mem[buf_addr] <= buf_wdata;
    end
  end

  // flash model: logs WE# pulses, drives read data {read index, cycles RE# low}
  always @(negedge clk) begin
    if (!we_n) begin
      we_low = we_low + 1; l_io = io_o; l_kind = {cle, ale}; l_ce = ce_n;
    end else if (we_low > 0) begin
      if (n_log < 64) begin
        log_byte[n_log] = l_io; log_kind[n_log] = l_kind;
        log_w[n_log] = we_low; log_ce[n_log] = l_ce;
      end
      n_log = n_log + 1; we_low = 0;
    end
    if (!re_n) re_low = re_low + 1;
    else if (re_low > 0) begin rd_idx = rd_idx + 1; re_low = 0; end
    io_i = {4'(rd_idx), 4'(re_low)};
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic wr, rd, input logic [3:0] sel, input logic [7:0] cmd,
                                     input logic wt, half, input logic [1:0] chip, input logic [9:0] len,
                                     input logic ien);
    return {1'b0, ien, wr, rd, sel, cmd, wt, half, chip, 2'b00, len};
  endfunction

  task automatic ctrl_write(input logic [31:0] w);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic ctrl_read();
    @(negedge clk); ctrl_rd = 1'b1;
    @(negedge clk); ctrl_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic addr_write(input logic [29:0] a);
    @(negedge clk); addr_wr = 1'b1; addr_wdata = a;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  // called at the negedge after the start edge; counts busy cycles
  task automatic run_to_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1", "busy", busy, 0);
    check("R1", "irq", irq, 0);
    check("R1", "cle/ale", {cle, ale}, 0);
    check("R1", "we_n/re_n", {we_n, re_n}, 2'b11);
    check("R1", "ce_n", ce_n, 4'hF);
    check("R1", "rdata", rdata, 0);
    check("R1", "wp_n", wp_n, 1);
  endtask

  task automatic t_cmd_addr_wait();
    int base, cyc, g;
    addr_write(30'h2A5B3C7D);
    rb = 1'b0;
    base = n_log;
    ctrl_write(mk(0, 0, 4'b1101, 8'h70, 1, 0, 2'd2, 10'd0, 0));
    check("R2", "busy after start", {rdata[31], busy}, 2'b11);
    check("R2", "cmd readback", rdata[23:16], 8'h70);
    g = 0;
    while (n_log < base + 4 && g < 200) begin g++; @(negedge clk); end
    repeat (6) @(negedge clk);
    check("R8", "busy while rb low", busy, 1);
    rb = 1'b1;
    run_to_idle(cyc);
    check("R3", "cmd byte", {log_kind[base], log_byte[base]}, {2'b10, 8'h70});
    check("R3", "cmd WE width", log_w[base], 2);
    check("R4", "addr byte0", {log_kind[base+1], log_byte[base+1]}, {2'b01, 8'h7D});
    check("R4", "addr byte2", {log_kind[base+2], log_byte[base+2]}, {2'b01, 8'h5B});
    check("R4", "addr byte3", {log_kind[base+3], log_byte[base+3]}, {2'b01, 8'h2A});
    check("R4", "byte count", n_log - base, 4);
    check("R7", "ce chip2", log_ce[base+2], 4'b1011);
    check("R9", "status set", rdata[30], 1);
    check("R9", "irq masked", irq, 0);
    ctrl_read();
    check("R9", "status cleared by read", rdata[30], 0);
  endtask

  task automatic t_write_data();
    int base, cyc;
    base = n_log;
    ctrl_write(mk(1, 0, 4'b0000, 8'h80, 0, 1, 2'd0, 10'd5, 1));
    check("R7", "ce chip0", ce_n, 4'b1110);
    run_to_idle(cyc);
    check("R5", "busy cycles", cyc, 29);
    for (int i = 0; i < 5; i++) begin
      check("R5", "wdata byte", {log_kind[base+1+i], log_byte[base+1+i]}, {2'b00, pat(512 + i)});
      check("R5", "wdata WE width", log_w[base+1+i], 3);
    end
    check("R9", "irq enabled", irq, 1);
  endtask

  task automatic t_read_data(input logic [31:0] cfg, input logic half, input int len, input logic [3:0] nib);
    int r0, cyc, off;
    cfg_write(cfg);
    r0 = rd_idx;
    off = half ? 512 : 0;
    ctrl_write(mk(0, 1, 4'b0000, 8'h00, 0, half, 2'd3, 10'(len), 0));
    check("R9", "start clears status", rdata[30], 0);
    run_to_idle(cyc);
    check("R6", "busy cycles", cyc, 4 + len * 6);
    check("R6", "RE pulses", rd_idx - r0, len);
    for (int i = 0; i < len; i++)
      check("R6", "rdata byte", mem[off+i], {4'(r0 + i), nib});
    check("R6", "byte past length", mem[off+len], pat(off + len));
    cfg_write(CFG_A);
  endtask

  task automatic t_stop();
    int g;
    ctrl_write(mk(1, 0, 4'b1111, 8'h85, 1, 0, 2'd1, 10'd20, 1));
    repeat (15) @(negedge clk);
    ctrl_write(32'h8000_0000);
    check("R10", "idle after stop", busy, 0);
    check("R10", "strobes", {cle, ale, we_n, re_n}, 4'b0011);
    check("R10", "ce_n", ce_n, 4'hF);
    repeat (30) @(negedge clk);
    check("R10", "no status", {rdata[31:30], irq}, 3'b000);
  endtask

  task automatic t_zero_len();
    int base, cyc;
    base = n_log;
    ctrl_write(mk(1, 0, 4'b0000, 8'h60, 0, 0, 2'd0, 10'd0, 0));
    run_to_idle(cyc);
    check("R11", "zero length busy", cyc, 4);
    check("R11", "zero length bytes", n_log - base, 1);
    check("R11", "zero length status", rdata[30], 1);
    ctrl_write(mk(0, 0, 4'b0000, 8'hFF, 0, 0, 2'd1, 10'd7, 0));
    run_to_idle(cyc);
    check("R3", "cmd-only busy", cyc, 4);
    check("R11", "cmd-only status", rdata[30], 1);
  endtask

  task automatic t_both();
    int base, r0, cyc;
    base = n_log; r0 = rd_idx;
    ctrl_write(mk(1, 1, 4'b0000, 8'h10, 0, 0, 2'd0, 10'd2, 0));
    run_to_idle(cyc);
    check("R5", "both: WE pulses", n_log - base, 3);
    check("R5", "both: RE pulses", rd_idx - r0, 0);
  endtask

  task automatic t_wp();
    cfg_write(CFG_A | 32'h8000_0000);
    check("R7", "wp asserted", wp_n, 0);
    cfg_write(CFG_A);
    check("R7", "wp released", wp_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_write(CFG_A);
    t_cmd_addr_wait();
    t_write_data();
    t_read_data(CFG_A, 1'b0, 4, 4'd2);
    t_read_data(CFG_B, 1'b1, 2, 4'd4);
    t_stop();
    t_zero_len();
    t_both();
    t_wp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule